// File: doc/BRIEF.md
# Shared Interrupt Target Router

This block holds the CPU routing of every shared interrupt line in an interrupt distributor. Each shared line is routed to exactly one CPU. Software reaches the routing through a 32-bit word port, where one word covers four consecutive interrupt lines with one 8-bit CPU mask per line. The port also carries the ID of the CPU making the access.

On a write, each byte is reduced to a single CPU. The lowest set bit of the byte picks the CPU, and an empty byte picks CPU 0. A read rebuilds a one-hot byte for each line from the stored choice. The words that cover the private lines, which are banked per CPU, are read-only. They read back the requesting CPU's own bit in every byte.

The block also drives a flat per-CPU bitmap of the shared lines. The pending-flag logic ANDs this bitmap with the enable and level state, so that a shared interrupt is raised on only one CPU.

Top module: `shared_irq_router`

## Requirements
- R1: After reset, every shared line is routed to CPU 0, so every shared word reads 0x01010101.
- R2: Word address `a` covers lines 4a to 4a+3. Byte `i` (bits 8i+7..8i) belongs to line 4a+i. Shared lines begin at line 32, which is word address 8.
- R3: A write to a shared word routes each of its four lines to the index of the least-significant set bit of that line's byte.
- R4: A byte written as 0x00 routes its line to CPU 0.
- R5: A read of a shared word returns, in each byte, a one-hot mask with only bit c set, where c is the stored target of that line. Read data follows the address and CPU ID combinationally.
- R6: For every shared line, exactly one CPU bit is set in `cpuTargetMap`. Bit `c*96 + (line-32)` is set when CPU c is the target. The map shows a write from the first clock edge after the write cycle.
- R7: Writes to word addresses 0 to 7 (lines 0 to 31) change no routing state.
- R8: A read of word addresses 0 to 7 returns `1 << cpuId` in each of the four bytes.
- R9: A write to one shared word leaves the routing of all lines in other words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Write strobe for the target word port |
| regAddr | input | 5 | Word address within the target region (word = lines 4a..4a+3) |
| regWrData | input | 32 | Write data: four 8-bit CPU masks |
| cpuId | input | 3 | ID of the CPU making the access |
| regRdData | output | 32 | Read data for `regAddr`, combinational |
| cpuTargetMap | output | 768 | Per-CPU target bitmap of the 96 shared lines, bit c*96+j for line 32+j |

## Verification
The assertions assume that `regAddr` and `cpuId` are stable and defined in every sampled cycle. They also assume that `cpuId` names one of the eight supported CPUs. The bench drives all inputs on the falling edge, and only with values in range, so every rising edge sees settled data. The bench holds `regWrEn` for exactly one cycle per write. This keeps the single-cycle lookback in the zero-byte and read-only properties aligned with one write.

// File: rtl/shared_irq_router_pkg.sv
package shared_irq_router_pkg;
  localparam int BYTE_W         = 8;
  localparam int LINES_PER_WORD = 4;
  localparam int WORD_W         = BYTE_W * LINES_PER_WORD;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrShared;  // write hits a shared-line word
    logic rdBanked;  // address selects a private (banked) word
  } routerStrobe_t;
endpackage

// File: rtl/shared_irq_router_ctrl.sv
module shared_irq_router_ctrl
  import shared_irq_router_pkg::*;
#(
  parameter int NUM_LINES  = 128,
  parameter int PRIV_LINES = 32,
  localparam int ADDR_W     = $clog2(NUM_LINES / LINES_PER_WORD),
  localparam int PRIV_WORDS = PRIV_LINES / LINES_PER_WORD
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output routerStrobe_t     strb,
  output logic [ADDR_W-1:0] sharedWord
);
  logic isBanked;

  always_comb begin
    isBanked      = (regAddr < ADDR_W'(PRIV_WORDS));
    strb.rdBanked = isBanked;
    strb.wrShared = regWrEn && !isBanked;
    sharedWord    = regAddr - ADDR_W'(PRIV_WORDS);
  end
endmodule

// File: rtl/shared_irq_router_dp.sv
module shared_irq_router_dp
  import shared_irq_router_pkg::*;
#(
  parameter int NUM_CPUS   = 8,
  parameter int NUM_LINES  = 128,
  parameter int PRIV_LINES = 32,
  localparam int ADDR_W       = $clog2(NUM_LINES / LINES_PER_WORD),
  localparam int IDX_W        = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
  localparam int SHARED_LINES = NUM_LINES - PRIV_LINES,
  localparam int SHARED_WORDS = SHARED_LINES / LINES_PER_WORD
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  routerStrobe_t                    strb,
  input  logic [ADDR_W-1:0]                sharedWord,
  input  logic [WORD_W-1:0]                regWrData,
  input  logic [IDX_W-1:0]                 cpuId,
  output logic [WORD_W-1:0]                regRdData,
  output logic [NUM_CPUS*SHARED_LINES-1:0] cpuTargetMap
);
  // One target index per shared line; the one-hot forms are rebuilt from it
  logic [IDX_W-1:0] tgtIdx [SHARED_LINES];

  function automatic logic [IDX_W-1:0] lowestSet(input logic [BYTE_W-1:0] b);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NUM_CPUS - 1; i >= 0; i--)
      if (b[i]) r = IDX_W'(i);
    return r;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int j = 0; j < SHARED_LINES; j++) tgtIdx[j] <= '0;
    end else if (strb.wrShared) begin
      for (int w = 0; w < SHARED_WORDS; w++)
        if (sharedWord == ADDR_W'(w))
          for (int b = 0; b < LINES_PER_WORD; b++)
            tgtIdx[w*LINES_PER_WORD+b] <= lowestSet(regWrData[b*BYTE_W +: BYTE_W]);
    end
  end

  logic [WORD_W-1:0] rdShared;
  logic [WORD_W-1:0] rdBank;

  always_comb begin
    rdShared = '0;
    for (int w = 0; w < SHARED_WORDS; w++)
      if (sharedWord == ADDR_W'(w))
        for (int b = 0; b < LINES_PER_WORD; b++)
          rdShared[b*BYTE_W +: BYTE_W] = BYTE_W'(1) << tgtIdx[w*LINES_PER_WORD+b];
    for (int b = 0; b < LINES_PER_WORD; b++)
      rdBank[b*BYTE_W +: BYTE_W] = BYTE_W'(1) << cpuId;
    regRdData = strb.rdBanked ? rdBank : rdShared;
  end

  // Per-CPU bitmap: line j of CPU c sits at bit c*SHARED_LINES+j
  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    for (genvar j = 0; j < SHARED_LINES; j++) begin : g_line
      assign cpuTargetMap[c*SHARED_LINES+j] = (tgtIdx[j] == IDX_W'(c));
    end
  end
endmodule

// File: rtl/shared_irq_router.sv
module shared_irq_router
  import shared_irq_router_pkg::*;
#(
  parameter int NUM_CPUS   = 8,   // at most one CPU per mask bit, so at most 8
  parameter int NUM_LINES  = 128,
  parameter int PRIV_LINES = 32,
  localparam int ADDR_W       = $clog2(NUM_LINES / LINES_PER_WORD),
  localparam int IDX_W        = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
  localparam int SHARED_LINES = NUM_LINES - PRIV_LINES
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             regWrEn,
  input  logic [ADDR_W-1:0]                regAddr,
  input  logic [WORD_W-1:0]                regWrData,
  input  logic [IDX_W-1:0]                 cpuId,
  output logic [WORD_W-1:0]                regRdData,
  output logic [NUM_CPUS*SHARED_LINES-1:0] cpuTargetMap
);
  routerStrobe_t     strb;
  logic [ADDR_W-1:0] sharedWord;

  shared_irq_router_ctrl #(.NUM_LINES(NUM_LINES), .PRIV_LINES(PRIV_LINES)) ctrl_i (
    .regWrEn(regWrEn), .regAddr(regAddr), .strb(strb), .sharedWord(sharedWord)
  );

  shared_irq_router_dp #(.NUM_CPUS(NUM_CPUS), .NUM_LINES(NUM_LINES),
                         .PRIV_LINES(PRIV_LINES)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .sharedWord(sharedWord),
    .regWrData(regWrData), .cpuId(cpuId), .regRdData(regRdData),
    .cpuTargetMap(cpuTargetMap)
  );
endmodule

// File: rtl/shared_irq_router_chk.sv
module shared_irq_router_chk
  import shared_irq_router_pkg::*;
#(
  parameter int NUM_CPUS   = 8,
  parameter int NUM_LINES  = 128,
  parameter int PRIV_LINES = 32,
  localparam int ADDR_W       = $clog2(NUM_LINES / LINES_PER_WORD),
  localparam int IDX_W        = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
  localparam int SHARED_LINES = NUM_LINES - PRIV_LINES,
  localparam int PRIV_WORDS   = PRIV_LINES / LINES_PER_WORD
) (
  input logic                             clk,
  input logic                             rstN,
  input logic                             regWrEn,
  input logic [ADDR_W-1:0]                regAddr,
  input logic [WORD_W-1:0]                regWrData,
  input logic [IDX_W-1:0]                 cpuId,
  input logic [WORD_W-1:0]                regRdData,
  input logic [NUM_CPUS*SHARED_LINES-1:0] cpuTargetMap
);
  // R6: one CPU per shared line
  for (genvar j = 0; j < SHARED_LINES; j++) begin : g_col
    logic [NUM_CPUS-1:0] col;
    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_bit
      assign col[c] = cpuTargetMap[c*SHARED_LINES+j];
    end
    assert_one_target_R6: assert property (@(posedge clk) disable iff (!rstN)
      $countones(col) == 1);
  end

  // R7: banked-word writes leave the routing map untouched
  assert_banked_wi_R7: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr < ADDR_W'(PRIV_WORDS)) |=> $stable(cpuTargetMap));

  // R8: banked words read the requester's bit in each byte
  assert_banked_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr < ADDR_W'(PRIV_WORDS)) |->
      (regRdData == {LINES_PER_WORD{BYTE_W'(1) << cpuId}}));

  // R5: shared words read one-hot in every byte
  for (genvar b = 0; b < LINES_PER_WORD; b++) begin : g_rd
    assert_read_onehot_R5: assert property (@(posedge clk) disable iff (!rstN)
      (regAddr >= ADDR_W'(PRIV_WORDS)) |->
        ($countones(regRdData[b*BYTE_W +: BYTE_W]) == 1));
  end

  // R4: empty low byte routes the first line of the word to CPU 0
  assert_zero_cpu0_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr >= ADDR_W'(PRIV_WORDS) && regWrData[BYTE_W-1:0] == '0) |=>
      cpuTargetMap[int'($past(regAddr)) * LINES_PER_WORD - PRIV_LINES]);
endmodule

bind shared_irq_router shared_irq_router_chk #(
  .NUM_CPUS(NUM_CPUS), .NUM_LINES(NUM_LINES), .PRIV_LINES(PRIV_LINES)
) chk_i (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .cpuId(cpuId), .regRdData(regRdData),
  .cpuTargetMap(cpuTargetMap)
);

// File: tb/shared_irq_router_tb_top.sv
module shared_irq_router_tb_top;
  localparam int NCPU = 8;
  localparam int NSH  = 96;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [2:0]  cpuId = '0;
  logic [31:0] regRdData;
  logic [NCPU*NSH-1:0] cpuTargetMap;

  int nChk = 0;
  int nErr = 0;
  int expTgt [NSH];

  always #5 clk = ~clk;

  shared_irq_router dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .cpuId(cpuId), .regRdData(regRdData),
    .cpuTargetMap(cpuTargetMap)
  );

  function automatic int lowIdx(input logic [7:0] b);
    for (int i = 0; i < 8; i++) if (b[i]) return i;
    return 0;
  endfunction

  function automatic logic [31:0] expWord(input int a);
    logic [31:0] v;
    for (int b = 0; b < 4; b++) v[b*8 +: 8] = 8'(1) << expTgt[(a-8)*4+b];
    return v;
  endfunction

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic readChk(input string tag, input int a, input int cpu, input logic [31:0] exp);
    @(negedge clk);
    regAddr = 5'(a);
    cpuId = 3'(cpu);
    #1 cmp(tag, regRdData, exp);
  endtask

  task automatic mapChk(input string tag);
    int bad = 0;
    int firstBad = -1;
    for (int j = 0; j < NSH; j++)
      for (int c = 0; c < NCPU; c++)
        if (cpuTargetMap[c*NSH+j] !== (expTgt[j] == c)) begin
          bad++;
          if (firstBad < 0) firstBad = c*NSH+j;
        end
    nChk++;
    if (bad != 0) begin
      nErr++;
      $display("FAIL %s: map has %0d wrong bits (first at %0d), expected 0", tag, bad, firstBad);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1;
    regAddr = 5'(a);
    regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    if (a >= 8)
      for (int b = 0; b < 4; b++) expTgt[(a-8)*4+b] = lowIdx(d[b*8 +: 8]);
  endtask

  task automatic tReset();
    for (int a = 8; a < 32; a++) readChk("R1 reset read", a, 0, 32'h01010101);
    mapChk("R1 reset map");
  endtask

  task automatic tOneHot();
    wr(8, 32'h80402010);           // lines 32..35 -> CPU 4,5,6,7 (R2)
    mapChk("R6 map after one-hot write");
    readChk("R2 byte order", 8, 0, 32'h80402010);
    readChk("R5 one-hot readback", 8, 0, expWord(8));
    wr(15, 32'h01020408);
    readChk("R5 readback word 15", 15, 3, 32'h01020408);
  endtask

  task automatic tMultiBit();
    wr(20, 32'h0CFF0603);          // CPUs 0,1,0,2 low->high byte
    readChk("R3 lowest set bit", 20, 0, 32'h04010201);
    mapChk("R3 map after multi-bit write");
  endtask

  task automatic tZero();
    wr(31, 32'h02020202);
    readChk("R3 pre-zero word", 31, 0, 32'h02020202);
    wr(31, 32'h00800000);
    readChk("R4 zero bytes to CPU 0", 31, 0, 32'h01800101);
    mapChk("R4 map after zero write");
  endtask

  task automatic tIsolation();
    readChk("R9 neighbour below", 19, 0, 32'h01010101);
    readChk("R9 neighbour above", 21, 0, 32'h01010101);
    readChk("R9 word 8 kept", 8, 0, 32'h80402010);
    mapChk("R9 full map");
  endtask

  task automatic tBanked();
    for (int c = 0; c < NCPU; c++)
      for (int a = 0; a < 8; a++) begin
        logic [7:0] m = 8'(1) << c;
        readChk("R8 banked read", a, c, {m, m, m, m});
      end
    wr(3, 32'hFFFFFFFF);
    wr(7, 32'h80808080);
    mapChk("R7 map after banked writes");
    readChk("R7 banked still read-only", 3, 5, 32'h20202020);
    readChk("R7 shared word untouched", 20, 0, 32'h04010201);
  endtask

  task automatic tBackToBack();
    @(negedge clk);
    for (int a = 9; a < 13; a++) begin
      regWrEn = 1'b1;
      regAddr = 5'(a);
      regWrData = 32'(a) << 3 | 32'h40000000;
      for (int b = 0; b < 4; b++) expTgt[(a-8)*4+b] = lowIdx(regWrData[b*8 +: 8]);
      @(negedge clk);
      mapChk("R6 map the cycle after write");
    end
    regWrEn = 1'b0;
    for (int a = 9; a < 13; a++) readChk("R5 back-to-back readback", a, 1, expWord(a));
  endtask

  initial begin
    for (int j = 0; j < NSH; j++) expTgt[j] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tOneHot();
    tMultiBit();
    tZero();
    tIsolation();
    tBanked();
    tBackToBack();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end

  initial begin
    #2000000;
    nChk++;
    nErr++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end
endmodule